// File: doc/BRIEF.md
# Configurable Asynchronous Frame Transmitter

This block serialises characters onto a single output line as asynchronous frames. A frame is a low start bit, then the character least significant bit first, then an optional parity bit, then a stop interval at the high level. Software-facing logic writes characters into a two-slot holding queue. The transmitter drains that queue whenever it is switched on. The bit timing comes from an oversampling tick that arrives sixteen times per bit period.

A 16-bit configuration word selects the character length, the parity mode and the stop interval. The transmitter takes a copy of these fields at the moment each frame begins. It is switched on and off by single-cycle command pulses. It reports three status levels: whether it is on, whether the queue has room (with a selectable threshold), and whether all transmission has finished. Each of the last two also produces a one-cycle pulse when it rises, so an interrupt controller can latch it. A write that finds the queue full is discarded, and the block flags the event with a pulse.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line is high, the transmitter is off, the queue is empty and the completion status is low. The line stays high whenever no frame is in flight.
- R2: A frame is one start bit at the low level, followed by the character least significant bit first. The character length comes from config bits [3:0]: codes 2, 3, 4 and 5 give 5, 6, 7 and 8 bits, and every other code gives 8 bits. Character bits above the length are not sent.
- R3: Config bits [9:8] set the parity: 00 or 01 means no parity bit, 10 means even, 11 means odd. When enabled, the parity bit follows the last data bit.
- R4: Every start, data and parity bit lasts 16 ticks. Config bits [13:12] set the stop interval: 00 gives 8 ticks, 01 gives 16, 10 gives 24 and 11 gives 32.
- R5: The queue holds two characters and sends them in write order. With ticks at least two cycles apart, the start of the next queued frame follows the end of the stop interval after a fixed delay. The start-to-start spacing is therefore exactly the frame length in ticks.
- R6: A write that finds both slots occupied is discarded, and the overflow output is high in that same cycle. The characters already queued are sent unchanged.
- R7: With the threshold input high, the room status is high when at most one slot is occupied. With it low, the room status is high only when the queue is empty. The status follows the level one cycle after a write or dequeue. A one-cycle room pulse marks each rise of the status.
- R8: The completion status rises when a stop interval ends with the queue empty, and a one-cycle completion pulse marks the rise. A write clears the status in the following cycle.
- R9: An enable pulse turns the transmitter on and a disable pulse turns it off, with the status updated on the next cycle. If both pulses arrive together, disable wins.
- R10: Turning the transmitter off during a frame lets that frame finish intact. No new frame starts while it is off, and writes are still queued.
- R11: The configuration fields are sampled when a frame starts. Changing them mid-frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversampling tick, 16 per bit period |
| wrStrobe | input | 1 | Write a character into the queue |
| wrData | input | DATA_W | Character to write |
| cmdEnable | input | 1 | One-cycle pulse that switches the transmitter on |
| cmdDisable | input | 1 | One-cycle pulse that switches the transmitter off |
| frameCfg | input | 16 | Length [3:0], parity [9:8], stop [13:12] |
| levelHalf | input | 1 | Room threshold: 1 means half empty, 0 means fully empty |
| txLine | output | 1 | Serial output, idles high |
| statEnabled | output | 1 | Transmitter is on |
| statBufRoom | output | 1 | Queue has room, per threshold |
| statTxDone | output | 1 | Queue and shifter are empty after the last stop |
| flagBufRoom | output | 1 | Pulse on rise of statBufRoom |
| flagTxDone | output | 1 | Pulse on rise of statTxDone |
| ovfPulse | output | 1 | Write discarded because the queue was full |

## Verification
The bench decodes the line as a receiver would. It sends a byte with bits set above a 5-bit length, to catch a design that fails to mask those bits and so produces a wrong parity or an extra bit. It measures the start-to-start spacing of queued frames for each of the four stop codes. A miscounted half-stop or two-stop interval shows up there as an off-by-8-tick error. It disables the transmitter in the middle of a frame, to catch a design that cuts the frame short or starts the frame still queued. It also changes the configuration mid-frame, to catch a design that reads the fields live. It fills the queue past capacity, applies enable and disable in the same cycle, and toggles the room threshold with one and two characters queued. A wrong overflow rule, a wrong command priority or a wrong threshold each changes a status bit or a received byte.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int CFG_W        = 16;
  localparam int CFG_LEN_LSB  = 0;
  localparam int CFG_PAR_LSB  = 8;
  localparam int CFG_STOP_LSB = 12;

  typedef enum logic [1:0] {
    LINE_MARK,
    LINE_SPACE,
    LINE_DATA,
    LINE_PARITY
  } lineSel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_e;

  // control to datapath strobes
  typedef struct packed {
    logic     loadShift;  // dequeue head into shifter, compute parity
    logic     shiftBit;   // advance to the next data bit
    lineSel_e lineSel;    // what the line shows this bit period
  } dpStrobe_t;

  // length code: 2..5 -> 5..8 bits, everything else -> 8 bits
  function automatic logic [3:0] decodeLen(input logic [3:0] code);
    case (code)
      4'd2:    decodeLen = 4'd5;
      4'd3:    decodeLen = 4'd6;
      4'd4:    decodeLen = 4'd7;
      default: decodeLen = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/uart_tx_datapath.sv
module uart_tx_datapath
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CFG_W-1:0]  frameCfg,
  input  dpStrobe_t         strobe,
  output logic [1:0]        bufCount,
  output logic              ovfPulse,
  output logic              txLine
);

  localparam int SLOTS = 2;

  logic [DATA_W-1:0] slotQ [SLOTS];
  logic              wrPtr;
  logic              rdPtr;
  logic [1:0]        countQ;
  logic [DATA_W-1:0] shiftQ;
  logic              parityQ;
  logic              wrAccept;
  logic [DATA_W-1:0] lenMask;
  logic [DATA_W-1:0] headMasked;
  logic [3:0]        lenNow;

  assign wrAccept = wrStrobe && (countQ != 2'(SLOTS));
  assign ovfPulse = wrStrobe && (countQ == 2'(SLOTS));
  assign bufCount = countQ;
  assign lenNow   = decodeLen(frameCfg[CFG_LEN_LSB +: 4]);

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      lenMask[i] = (i < int'(lenNow));
    end
    headMasked = slotQ[rdPtr] & lenMask;
  end

  // holding queue
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= 1'b0;
      rdPtr  <= 1'b0;
      countQ <= '0;
      for (int i = 0; i < SLOTS; i++) slotQ[i] <= '0;
    end else begin
      if (wrAccept) begin
        slotQ[wrPtr] <= wrData;
        wrPtr        <= ~wrPtr;
      end
      if (strobe.loadShift) rdPtr <= ~rdPtr;
      countQ <= countQ + 2'(wrAccept) - 2'(strobe.loadShift);
    end
  end

  // shifter and parity
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '0;
      parityQ <= 1'b0;
    end else if (strobe.loadShift) begin
      shiftQ  <= headMasked;
      parityQ <= (^headMasked) ^ frameCfg[CFG_PAR_LSB];
    end else if (strobe.shiftBit) begin
      shiftQ  <= shiftQ >> 1;
    end
  end

  always_comb begin
    case (strobe.lineSel)
      LINE_SPACE:  txLine = 1'b0;
      LINE_DATA:   txLine = shiftQ[0];
      LINE_PARITY: txLine = parityQ;
      default:     txLine = 1'b1;
    endcase
  end

  assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= 2'(SLOTS))
    else $error("queue level above capacity");

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && countQ == 2'(SLOTS) && !strobe.loadShift) |=> countQ == 2'(SLOTS))
    else $error("write into full queue changed its level");

  assert_load_nonempty_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadShift |-> countQ != 2'd0)
    else $error("dequeue from empty queue");

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             cmdEnable,
  input  logic             cmdDisable,
  input  logic             wrStrobe,
  input  logic [CFG_W-1:0] frameCfg,
  input  logic             levelHalf,
  input  logic [1:0]       bufCount,
  output dpStrobe_t        strobe,
  output logic             statEnabled,
  output logic             statBufRoom,
  output logic             statTxDone,
  output logic             flagBufRoom,
  output logic             flagTxDone
);

  localparam int TICK_W = $clog2(2 * TICKS_PER_BIT);
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int HALF   = TICKS_PER_BIT / 2;
  localparam logic [TICK_W-1:0] BIT_LAST   = TICK_W'(TICKS_PER_BIT - 1);
  localparam logic [TICK_W-1:0] STOP_HALF  = TICK_W'(HALF - 1);
  localparam logic [TICK_W-1:0] STOP_ONE   = TICK_W'(TICKS_PER_BIT - 1);
  localparam logic [TICK_W-1:0] STOP_ONEHF = TICK_W'(TICKS_PER_BIT + HALF - 1);
  localparam logic [TICK_W-1:0] STOP_TWO   = TICK_W'(2 * TICKS_PER_BIT - 1);

  txState_e          state;
  lineSel_e          lineSelQ;
  logic [TICK_W-1:0] tickLeft;
  logic [BIT_W-1:0]  bitLeft;
  logic [3:0]        lenLat;
  logic              parLat;
  logic [1:0]        stopLat;
  logic [TICK_W-1:0] stopLast;
  logic              enabledQ;
  logic              txDoneQ;
  logic              roomPrev;
  logic              donePrev;
  logic              periodEnd;
  logic              stopEnd;

  assign periodEnd = tick && (tickLeft == '0);
  assign stopEnd   = (state == ST_STOP) && periodEnd;

  always_comb begin
    case (stopLat)
      2'b00:   stopLast = STOP_HALF;
      2'b01:   stopLast = STOP_ONE;
      2'b10:   stopLast = STOP_ONEHF;
      default: stopLast = STOP_TWO;
    endcase
  end

  always_comb begin
    strobe.loadShift = (state == ST_IDLE) && enabledQ && (bufCount != 2'd0);
    strobe.shiftBit  = (state == ST_DATA) && periodEnd && (bitLeft != '0);
    strobe.lineSel   = lineSelQ;
  end

  // frame sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      lineSelQ <= LINE_MARK;
      tickLeft <= '0;
      bitLeft  <= '0;
      lenLat   <= 4'd8;
      parLat   <= 1'b0;
      stopLat  <= 2'b01;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strobe.loadShift) begin
            state    <= ST_START;
            lineSelQ <= LINE_SPACE;
            tickLeft <= BIT_LAST;
            lenLat   <= decodeLen(frameCfg[CFG_LEN_LSB +: 4]);
            parLat   <= frameCfg[CFG_PAR_LSB + 1];
            stopLat  <= frameCfg[CFG_STOP_LSB +: 2];
          end
        end
        ST_START: begin
          if (periodEnd) begin
            state    <= ST_DATA;
            lineSelQ <= LINE_DATA;
            tickLeft <= BIT_LAST;
            bitLeft  <= BIT_W'(lenLat - 4'd1);
          end else if (tick) begin
            tickLeft <= tickLeft - 1'b1;
          end
        end
        ST_DATA: begin
          if (periodEnd) begin
            if (bitLeft != '0) begin
              bitLeft  <= bitLeft - 1'b1;
              tickLeft <= BIT_LAST;
            end else if (parLat) begin
              state    <= ST_PARITY;
              lineSelQ <= LINE_PARITY;
              tickLeft <= BIT_LAST;
            end else begin
              state    <= ST_STOP;
              lineSelQ <= LINE_MARK;
              tickLeft <= stopLast;
            end
          end else if (tick) begin
            tickLeft <= tickLeft - 1'b1;
          end
        end
        ST_PARITY: begin
          if (periodEnd) begin
            state    <= ST_STOP;
            lineSelQ <= LINE_MARK;
            tickLeft <= stopLast;
          end else if (tick) begin
            tickLeft <= tickLeft - 1'b1;
          end
        end
        default: begin
          if (periodEnd) begin
            state    <= ST_IDLE;
            lineSelQ <= LINE_MARK;
          end else if (tick) begin
            tickLeft <= tickLeft - 1'b1;
          end
        end
      endcase
    end
  end

  // enable, completion and flag edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enabledQ <= 1'b0;
      txDoneQ  <= 1'b0;
      roomPrev <= 1'b1;
      donePrev <= 1'b0;
    end else begin
      if (cmdDisable)     enabledQ <= 1'b0;
      else if (cmdEnable) enabledQ <= 1'b1;
      if (wrStrobe)                              txDoneQ <= 1'b0;
      else if (stopEnd && bufCount == 2'd0)      txDoneQ <= 1'b1;
      roomPrev <= statBufRoom;
      donePrev <= txDoneQ;
    end
  end

  assign statEnabled = enabledQ;
  assign statTxDone  = txDoneQ;
  assign statBufRoom = levelHalf ? (bufCount <= 2'd1) : (bufCount == 2'd0);
  assign flagBufRoom = statBufRoom && !roomPrev;
  assign flagTxDone  = txDoneQ && !donePrev;

  assert_disable_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmdDisable |=> !statEnabled)
    else $error("disable pulse did not switch transmitter off");

  assert_enable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdEnable && !cmdDisable) |=> statEnabled)
    else $error("enable pulse ignored");

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    statTxDone |-> (state == ST_IDLE && bufCount == 2'd0))
    else $error("completion reported while work remains");

  assert_no_start_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !enabledQ) |=> state == ST_IDLE)
    else $error("frame started while transmitter off");

  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> (lineSelQ == LINE_MARK))
    else $error("line not at mark while idle");

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cmdEnable,
  input  logic              cmdDisable,
  input  logic [15:0]       frameCfg,
  input  logic              levelHalf,
  output logic              txLine,
  output logic              statEnabled,
  output logic              statBufRoom,
  output logic              statTxDone,
  output logic              flagBufRoom,
  output logic              flagTxDone,
  output logic              ovfPulse
);

  dpStrobe_t  strobe;
  logic [1:0] bufCount;

  uart_tx_ctrl #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .DATA_W       (DATA_W)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .cmdEnable  (cmdEnable),
    .cmdDisable (cmdDisable),
    .wrStrobe   (wrStrobe),
    .frameCfg   (frameCfg),
    .levelHalf  (levelHalf),
    .bufCount   (bufCount),
    .strobe     (strobe),
    .statEnabled(statEnabled),
    .statBufRoom(statBufRoom),
    .statTxDone (statTxDone),
    .flagBufRoom(flagBufRoom),
    .flagTxDone (flagTxDone)
  );

  uart_tx_datapath #(
    .DATA_W(DATA_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrStrobe(wrStrobe),
    .wrData  (wrData),
    .frameCfg(frameCfg),
    .strobe  (strobe),
    .bufCount(bufCount),
    .ovfPulse(ovfPulse),
    .txLine  (txLine)
  );

endmodule

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        wrStrobe = 1'b0;
  logic [7:0]  wrData = '0;
  logic        cmdEnable = 1'b0;
  logic        cmdDisable = 1'b0;
  logic [15:0] frameCfg = 16'h1005;
  logic        levelHalf = 1'b1;
  logic        txLine, statEnabled, statBufRoom, statTxDone;
  logic        flagBufRoom, flagTxDone, ovfPulse;

  int errors = 0;
  int total  = 0;
  int cyc    = 0;
  int fallCount = 0;
  int lastFall  = 0;
  int prevFall  = 0;
  int roomFlags = 0;
  int doneFlags = 0;
  int ovfCount  = 0;
  int tickDiv   = 0;
  logic prevLine = 1'b1;

  always #4 clk = ~clk;  // 125 MHz

  uart_frame_tx dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .wrStrobe(wrStrobe), .wrData(wrData),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable), .frameCfg(frameCfg),
    .levelHalf(levelHalf), .txLine(txLine), .statEnabled(statEnabled),
    .statBufRoom(statBufRoom), .statTxDone(statTxDone), .flagBufRoom(flagBufRoom),
    .flagTxDone(flagTxDone), .ovfPulse(ovfPulse)
  );

  // tick every 4 cycles, driven away from the active edge
  always @(negedge clk) begin
    tickDiv = (tickDiv + 1) % 4;
    tick <= (tickDiv == 3);
  end

  // line and flag monitors, sampled at the falling edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rstN) begin
      if (prevLine && !txLine) begin
        fallCount = fallCount + 1;
        prevFall  = lastFall;
        lastFall  = cyc;
      end
      if (flagBufRoom) roomFlags = roomFlags + 1;
      if (flagTxDone)  doneFlags = doneFlags + 1;
      if (ovfPulse)    ovfCount  = ovfCount + 1;
    end
    prevLine = txLine;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total = total + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeChar(input logic [7:0] d);
    wrData = d; wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic pulseCmd(input logic en, input logic dis);
    cmdEnable = en; cmdDisable = dis;
    @(negedge clk);
    cmdEnable = 1'b0; cmdDisable = 1'b0;
  endtask

  // receiver: 4 cycles per tick, 64 cycles per bit
  task automatic recvFrame(input int nBits, input bit parEn,
                           output logic [7:0] d, output logic p, output logic s);
    int t = 0;
    d = '0; p = 1'b0;
    while (txLine !== 1'b0 && t < 20000) begin @(negedge clk); t++; end
    cycles(32);
    for (int i = 0; i < nBits; i++) begin cycles(64); d[i] = txLine; end
    if (parEn) begin cycles(64); p = txLine; end
    cycles(40);
    s = txLine;
    cycles(40);
  endtask

  task automatic testReset();
    chk("R1 reset line",      txLine, 1);
    chk("R1 reset enabled",   statEnabled, 0);
    chk("R1 reset txdone",    statTxDone, 0);
    chk("R1 reset room",      statBufRoom, 1);
  endtask

  task automatic testBasic();
    logic [7:0] d; logic p, s;
    frameCfg = 16'h1005;
    pulseCmd(1'b1, 1'b0);
    chk("R9 enabled after pulse", statEnabled, 1);
    writeChar(8'hA5);
    recvFrame(8, 0, d, p, s);
    chk("R2 8-bit data", d, 8'hA5);
    chk("R4 stop high", s, 1);
    frameCfg = 16'h1000;  // unlisted length code -> 8 bits
    writeChar(8'h81);
    recvFrame(8, 0, d, p, s);
    chk("R2 default length", d, 8'h81);
    cycles(100);
    chk("R1 idle high", txLine, 1);
  endtask

  task automatic testParity();
    logic [7:0] d; logic p, s;
    frameCfg = 16'h1204;  // 7 bits, even
    writeChar(8'h15);
    fork
      recvFrame(7, 1, d, p, s);
      begin cycles(150); frameCfg = 16'h0005; end
    join
    chk("R11 data under mid-frame cfg change", d, 8'h15);
    chk("R3 even parity bit", p, 1);
    chk("R11 stop after parity", s, 1);
    frameCfg = 16'h1302;  // 5 bits, odd
    writeChar(8'hEB);
    recvFrame(5, 1, d, p, s);
    chk("R2 masked 5-bit data", d, 8'h0B);
    chk("R3 odd parity bit", p, 0);
    chk("R3 stop after parity", s, 1);
  endtask

  task automatic testStops();
    logic [7:0] d; logic p, s;
    for (int code = 0; code < 4; code++) begin
      int stopTicks = (code == 0) ? 8 : (code == 1) ? 16 : (code == 2) ? 24 : 32;
      int f0;
      frameCfg = 16'h0005 | 16'(code << 12);
      cycles(200);
      f0 = fallCount;
      writeChar(8'hFF); writeChar(8'hFF); writeChar(8'hFF);
      while (fallCount < f0 + 3) @(negedge clk);
      chk($sformatf("R4 R5 stop code %0d spacing", code), lastFall - prevFall,
          (144 + stopTicks) * 4);
      recvFrame(8, 0, d, p, s);
      chk("R5 last queued frame", d, 8'hFF);
    end
  endtask

  task automatic testThreshold();
    logic [7:0] d; logic p, s;
    int rf;
    frameCfg = 16'h1005;
    cycles(400);
    pulseCmd(1'b0, 1'b1);
    levelHalf = 1'b1;
    cycles(2);
    chk("R7 half threshold empty", statBufRoom, 1);
    writeChar(8'h3C);
    chk("R7 half threshold one entry", statBufRoom, 1);
    writeChar(8'hC3);
    chk("R7 half threshold full", statBufRoom, 0);
    levelHalf = 1'b0;
    cycles(1);
    chk("R7 empty threshold full", statBufRoom, 0);
    levelHalf = 1'b1;
    cycles(1);
    rf = roomFlags;
    pulseCmd(1'b1, 1'b0);
    cycles(3);
    chk("R7 room pulse on dequeue", roomFlags - rf, 1);
    recvFrame(8, 0, d, p, s);
    chk("R5 first in order", d, 8'h3C);
    recvFrame(8, 0, d, p, s);
    chk("R5 second in order", d, 8'hC3);
  endtask

  task automatic testOverflow();
    logic [7:0] d; logic p, s;
    int f0, ov0;
    cycles(200);
    pulseCmd(1'b0, 1'b1);
    ov0 = ovfCount;
    writeChar(8'h11); writeChar(8'h22); writeChar(8'h33);
    chk("R6 overflow pulse count", ovfCount - ov0, 1);
    pulseCmd(1'b1, 1'b0);
    recvFrame(8, 0, d, p, s);
    chk("R6 first kept", d, 8'h11);
    recvFrame(8, 0, d, p, s);
    chk("R6 second kept", d, 8'h22);
    f0 = fallCount;
    cycles(900);
    chk("R6 dropped char not sent", fallCount - f0, 0);
  endtask

  task automatic testDoneAndDisable();
    logic [7:0] d; logic p, s;
    int f0, dn0;
    cycles(100);
    dn0 = doneFlags;
    writeChar(8'h5A);
    chk("R8 write clears done", statTxDone, 0);
    fork
      recvFrame(8, 0, d, p, s);
      begin cycles(200); pulseCmd(1'b0, 1'b1); end
    join
    chk("R10 frame finishes after disable", d, 8'h5A);
    chk("R10 stop intact", s, 1);
    chk("R9 off after disable", statEnabled, 0);
    cycles(100);
    chk("R8 done after last stop", statTxDone, 1);
    chk("R8 done pulse", doneFlags - dn0, 1);
    levelHalf = 1'b0;
    f0 = fallCount;
    writeChar(8'h77);
    cycles(1000);
    chk("R10 no frame while off", fallCount - f0, 0);
    chk("R10 write queued while off", statBufRoom, 0);
    pulseCmd(1'b1, 1'b1);
    chk("R9 disable wins", statEnabled, 0);
    cycles(300);
    chk("R9 still no frame", fallCount - f0, 0);
    pulseCmd(1'b1, 1'b0);
    recvFrame(8, 0, d, p, s);
    chk("R10 queued char sent after enable", d, 8'h77);
    levelHalf = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors = errors + 1;
    total  = total + 1;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    cycles(5);
    testReset();
    rstN = 1'b1;
    cycles(5);
    testReset();
    testBasic();
    testParity();
    testStops();
    testThreshold();
    testOverflow();
    testDoneAndDisable();
    finishRun();
  end

endmodule